// File: doc/BRIEF.md
# Byte Shift Unit with Flag Generation

This block carries out the four single-bit shift operations of an 8-bit processor's prefixed bit-manipulation group. Each request brings a one-byte instruction code and a one-byte operand. The unit shifts the operand and builds the complete eight-bit flag byte. It registers the result, the flags and the operand-select field of the instruction. All of these appear one clock after the request.

Instruction bits 4:3 pick the operation, once bits 7:5 have identified a shift. There are two left shifts: one fills bit 0 with zero and the other forces bit 0 to one. There are two right shifts: one keeps the sign bit and the other fills bit 7 with zero. Codes outside the shift group raise a one-cycle illegal indication and leave the stored result and flags untouched. The operand-select field is passed through, together with a decoded memory-form bit, so that the surrounding datapath can steer writeback.

Top module: `shu_top`

## Requirements
- R1: A request is legal only when code bits 7:5 equal 3'b001. Any other code makes `res_illegal` high together with `res_valid`, and `res_data` and `res_flags` keep their previous values.
- R2: `res_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: Code bits 4:3 = 2'b00 shifts left, fills bit 0 with 0 and takes carry from old bit 7.
- R4: Code bits 4:3 = 2'b01 shifts right, copies old bit 7 into new bit 7 and takes carry from old bit 0.
- R5: Code bits 4:3 = 2'b10 shifts left and forces bit 0 to 1. Carry comes from old bit 7, and because the result is never zero the zero flag is always 0.
- R6: Code bits 4:3 = 2'b11 shifts right, fills bit 7 with 0 and takes carry from old bit 0.
- R7: The flag byte, from bit 7 down to bit 0, is: sign (result bit 7), zero (result == 0), a copy of result bit 5, half-carry (always 0), a copy of result bit 3, parity (1 when the result has an even number of ones), subtract (always 0), carry.
- R8: `res_sel` is code bits 2:0 of the last request, legal or not. `res_mem` is 1 exactly when that field is 3'b110.
- R9: While reset is asserted and after reset, until the first request, all outputs are 0.
- R10: In a cycle without a request, `res_data` and `res_flags` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_code | input | 8 | Instruction byte |
| req_operand | input | 8 | Operand byte |
| res_valid | output | 1 | Result strobe, one cycle after request |
| res_data | output | 8 | Shifted byte |
| res_flags | output | 8 | Flag byte |
| res_sel | output | 3 | Operand-select field of the request |
| res_mem | output | 1 | Operand-select field denotes the memory form |
| res_illegal | output | 1 | Request code was not a shift |

## Verification
An illegal-code rejection and an operand-select pass-through fall in the same cycle: the unit must refresh `res_sel` and `res_mem` while it freezes `res_data` and `res_flags`. The bench provokes this with directed non-shift codes whose select field is 3'b110 and with random codes, many outside the shift group, issued back to back after legal ones. It judges each result against a reference model that holds the last legal result and flags and tracks the select field of every request. A second overlap is the forced-one fill of the left shift combined with the zero and parity flags. Operands of 0x00 and 0x80 exercise it.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned SELW = 3;

  typedef enum logic [1:0] {
    SH_LEFT_ZERO = 2'b00,
    SH_RIGHT_SGN = 2'b01,
    SH_LEFT_ONE  = 2'b10,
    SH_RIGHT_LOG = 2'b11
  } shu_op_e;

  localparam logic [2:0]      GROUP_CODE = 3'b001;
  localparam logic [SELW-1:0] SEL_MEM    = 3'b110;

  localparam int unsigned FL_S  = 7;
  localparam int unsigned FL_Z  = 6;
  localparam int unsigned FL_B5 = 5;
  localparam int unsigned FL_H  = 4;
  localparam int unsigned FL_B3 = 3;
  localparam int unsigned FL_P  = 2;
  localparam int unsigned FL_N  = 1;
  localparam int unsigned FL_C  = 0;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
(
  input  logic [7:0]      code,
  output logic            legal,
  output shu_op_e         op,
  output logic [SELW-1:0] sel,
  output logic            is_mem
);
  always_comb begin
    legal  = (code[7:5] == GROUP_CODE);
    op     = shu_op_e'(code[4:3]);
    sel    = code[SELW-1:0];
    is_mem = (code[SELW-1:0] == SEL_MEM);
  end
endmodule

// File: rtl/shu_shifter.sv
module shu_shifter
  import shu_pkg::*;
(
  input  shu_op_e       op,
  input  logic [DW-1:0] a,
  output logic [DW-1:0] r,
  output logic          c
);
  localparam int unsigned MSB = DW - 1;

  logic go_left;
  logic fill_lo;
  logic fill_hi;

  always_comb begin
    go_left = (op == SH_LEFT_ZERO) || (op == SH_LEFT_ONE);
    fill_lo = (op == SH_LEFT_ONE);
    fill_hi = (op == SH_RIGHT_SGN) ? a[MSB] : 1'b0;
    c       = go_left ? a[MSB] : a[0];
  end

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_lane
      if (i == 0) begin : g_lo
        assign r[i] = go_left ? fill_lo : a[i+1];
      end else if (i == MSB) begin : g_hi
        assign r[i] = go_left ? a[i-1] : fill_hi;
      end else begin : g_mid
        assign r[i] = go_left ? a[i-1] : a[i+1];
      end
    end
  endgenerate

  always_comb begin
    if (op == SH_LEFT_ONE) begin
      p_one_fill_r5: assert (r[0] == 1'b1);
    end
  end
endmodule

// File: rtl/shu_flaggen.sv
module shu_flaggen
  import shu_pkg::*;
(
  input  logic [DW-1:0] r,
  input  logic          c,
  output logic [7:0]    flags
);
  logic odd;

  always_comb begin
    odd = 1'b0;
    for (int k = 0; k < DW; k++) begin
      odd = odd ^ r[k];
    end
  end

  always_comb begin
    flags        = '0;
    flags[FL_S]  = r[DW-1];
    flags[FL_Z]  = (r == '0);
    flags[FL_B5] = r[5];
    flags[FL_H]  = 1'b0;
    flags[FL_B3] = r[3];
    flags[FL_P]  = ~odd;
    flags[FL_N]  = 1'b0;
    flags[FL_C]  = c;
  end
endmodule

// File: rtl/shu_top.sv
module shu_top
  import shu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [7:0]      req_code,
  input  logic [DW-1:0]   req_operand,
  output logic            res_valid,
  output logic [DW-1:0]   res_data,
  output logic [7:0]      res_flags,
  output logic [SELW-1:0] res_sel,
  output logic            res_mem,
  output logic            res_illegal
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  logic            dec_legal, dec_mem;
  shu_op_e         dec_op;
  logic [SELW-1:0] dec_sel;
  logic [DW-1:0]   sh_r;
  logic            sh_c;
  logic [7:0]      fl_w;

  shu_decode u_dec (
    .code   (req_code),
    .legal  (dec_legal),
    .op     (dec_op),
    .sel    (dec_sel),
    .is_mem (dec_mem)
  );

  shu_shifter u_sh (
    .op (dec_op),
    .a  (req_operand),
    .r  (sh_r),
    .c  (sh_c)
  );

  shu_flaggen u_fl (
    .r     (sh_r),
    .c     (sh_c),
    .flags (fl_w)
  );

  // next-state
  logic            en_data, en_sel;
  logic            valid_d, illegal_d, mem_d;
  logic [DW-1:0]   data_d;
  logic [7:0]      flags_d;
  logic [SELW-1:0] sel_d;

  always_comb begin
    en_data   = req_valid && dec_legal;
    en_sel    = req_valid;
    valid_d   = req_valid;
    illegal_d = req_valid && !dec_legal;
    data_d    = en_data ? sh_r : res_data;
    flags_d   = en_data ? fl_w : res_flags;
    sel_d     = en_sel ? dec_sel : res_sel;
    mem_d     = en_sel ? dec_mem : res_mem;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      res_valid   <= 1'b0;
      res_illegal <= 1'b0;
      res_data    <= '0;
      res_flags   <= '0;
      res_sel     <= '0;
      res_mem     <= 1'b0;
    end else begin
      res_valid   <= valid_d;
      res_illegal <= illegal_d;
      res_data    <= data_d;
      res_flags   <= flags_d;
      res_sel     <= sel_d;
      res_mem     <= mem_d;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid |=> res_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> !res_valid);
  p_illegal_hold_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_code[7:5] != 3'b001) |=> (res_illegal && $stable(res_data) && $stable(res_flags)));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> ($stable(res_data) && $stable(res_flags)));
  p_hn_clear_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    res_valid |-> (res_flags[FL_H] == 1'b0 && res_flags[FL_N] == 1'b0));
  p_one_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_code[7:3] == 5'b00110) |=> (!res_flags[FL_Z] && res_data[0]));
  p_right_carry_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && req_code[7:5] == 3'b001 && req_code[3]) |=> (res_flags[FL_C] == $past(req_operand[0])));
  p_mem_sel_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    res_valid |-> (res_mem == (res_sel == 3'b110)));
endmodule

// File: tb/test_shu_top.sv
module test_shu_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_code, req_operand;
  logic       res_valid, res_mem, res_illegal;
  logic [7:0] res_data, res_flags;
  logic [2:0] res_sel;

  int total = 0;
  int bad   = 0;

  logic [7:0] exp_data, exp_flags;
  logic [2:0] exp_sel;

  always #2 clk = ~clk;

  shu_top i_shu_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_operand(req_operand), .res_valid(res_valid), .res_data(res_data),
    .res_flags(res_flags), .res_sel(res_sel), .res_mem(res_mem),
    .res_illegal(res_illegal)
  );

  function automatic logic [15:0] ref_op(input logic [7:0] code, input logic [7:0] a);
    logic [7:0] r;
    logic       c;
    case (code[4:3])
      2'b00:   begin r = {a[6:0], 1'b0}; c = a[7]; end
      2'b01:   begin r = {a[7], a[7:1]}; c = a[0]; end
      2'b10:   begin r = {a[6:0], 1'b1}; c = a[7]; end
      default: begin r = {1'b0, a[7:1]}; c = a[0]; end
    endcase
    return {r, r[7], (r == 8'h00), r[5], 1'b0, r[3], ~(^r), 1'b0, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; checks outputs at the next negedge
  task automatic issue(input logic v, input logic [7:0] code, input logic [7:0] a);
    logic [15:0] m;
    logic        legal;
    req_valid   = v;
    req_code    = code;
    req_operand = a;
    legal = (code[7:5] == 3'b001);
    if (v) begin
      exp_sel = code[2:0];
      if (legal) begin
        m = ref_op(code, a);
        exp_data  = m[15:8];
        exp_flags = m[7:0];
      end
    end
    @(negedge clk);
    chk("R2 valid", {31'd0, res_valid}, {31'd0, v});
    chk("R1 illegal", {31'd0, res_illegal}, {31'd0, v && !legal});
    chk("R3-6 data R10", {24'd0, res_data}, {24'd0, exp_data});
    chk("R7 flags", {24'd0, res_flags}, {24'd0, exp_flags});
    chk("R8 sel", {29'd0, res_sel}, {29'd0, exp_sel});
    chk("R8 mem", {31'd0, res_mem}, {31'd0, exp_sel == 3'b110});
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_operand = '0;
    exp_data = '0; exp_flags = '0; exp_sel = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 valid", {31'd0, res_valid}, 32'd0);
    chk("R9 data", {24'd0, res_data}, 32'd0);
    chk("R9 flags", {24'd0, res_flags}, 32'd0);
    chk("R9 illegal", {31'd0, res_illegal}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after release", {24'd0, res_flags}, 32'd0);

    // directed corners
    issue(1, 8'h20, 8'h80);  // R3: result 0, Z,P,C -> 8'h45
    chk("R3 corner flags", {24'd0, res_flags}, 32'h45);
    issue(1, 8'h28, 8'h81);  // R4: 0xC0, carry
    chk("R4 corner data", {24'd0, res_data}, 32'hC0);
    issue(1, 8'h36, 8'h00);  // R5: 0x01, Z clear, mem form
    chk("R5 corner data", {24'd0, res_data}, 32'h01);
    chk("R5 corner Z", {31'd0, res_flags[6]}, 32'd0);
    issue(1, 8'h38, 8'h01);  // R6: result 0, Z and C
    chk("R6 corner data", {24'd0, res_data}, 32'h00);
    issue(1, 8'h3E, 8'hFF);  // R6: 0x7F
    issue(1, 8'h06, 8'h55);  // R1: illegal with mem select
    issue(1, 8'hCB, 8'h12);  // R1
    issue(0, 8'h20, 8'hAA);  // R10 idle
    issue(1, 8'h2D, 8'h40);  // R4 positive
    issue(1, 8'h31, 8'h80);  // R5 carry out

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] code;
      code = 8'($urandom);
      if (($urandom % 4) != 0) code[7:5] = 3'b001;
      issue(($urandom % 5) != 0, code, 8'($urandom));
    end
    issue(0, 8'h00, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule